// File: doc/BRIEF.md
# Endpoint DMA Transfer Controller

This block runs one DMA transfer at a time between a chosen endpoint buffer and a DMA bus. Firmware sets it up through a small write/read register port. It names the buffer, loads a byte count, and then writes a start command for either the generic mode or the memory mode. While the transfer runs, the byte stream is modelled as a per-byte valid strobe and a packet-end strobe. Each accepted byte takes one off the counter.

A transfer ends in one of three ways: the counter runs out, a short or empty packet arrives, or firmware aborts the mode that is running. A start is also refused when the DMA buffer matches the buffer that firmware is addressing through its endpoint-index register. Each cause sets a sticky bit in the reason register, and firmware clears these bits by writing 1s. One interrupt line is raised when any enabled reason bit is set.

Top module: `edma_ctrl`

Register map (word address on `reg_waddr_i` / `reg_raddr_i`):

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | endpoint index | read/write | endpoint addressed by firmware, bits [EP_W-1:0] |
| 1 | DMA endpoint | read/write | endpoint buffer used by the DMA, bits [EP_W-1:0] |
| 2 | byte counter | read/write | bytes left; a write loads it only while idle |
| 3 | command | write | code in bits [3:0]; reads 0 |
| 4 | reason | read, write 1 to clear | sticky termination causes |
| 5 | interrupt mask | read/write | one enable per reason bit |
| 6 | status | read | bit0 busy, bit1 mode (0 generic, 1 memory) |

Command codes: 1 reset, 2 start generic, 3 start memory, 4 stop generic, 5 stop memory.

Reason bits: bit0 count done, bit1 short/empty packet, bit2 generic abort, bit3 memory abort, bit4 configuration error.

## Requirements
- R1: Command code 1 returns these to their power-on values: busy, mode, counter, DMA endpoint, reason register (reads 0) and mask (reads 0). The endpoint-index register keeps its value, and `irq_o` reads 0 afterwards.
- R2: Command code 2 or 3, written while idle with a nonzero count, sets status bit0 (busy). Status bit1 reads 0 for code 2 and 1 for code 3.
- R3: While busy, each cycle with `byte_vld_i` high takes one off the counter (address 2).
- R4: When the counter reaches zero through an accepted byte, the transfer ends: busy clears and reason bit0 is set.
- R5: While busy, `pkt_end_i` ends the transfer before the count runs out. Busy clears, reason bit1 is set, and the counter keeps the bytes that remain.
- R6: A last byte that arrives together with `pkt_end_i` and takes the counter from 1 to 0 sets reason bits 0 and 1 in the same cycle, and busy clears.
- R7: Stop code 4 during a generic transfer sets reason bit2, and stop code 5 during a memory transfer sets reason bit3. In both cases busy clears.
- R8: A stop code for the mode that is not running is ignored. So is any stop code while idle. Neither sets a reason bit, and busy does not change.
- R9: A start code while the DMA endpoint equals the endpoint index is refused: busy stays 0 and reason bit4 is set.
- R10: Reason bits stay set until firmware writes 1 to them at address 4. `irq_o` is high exactly when a set reason bit has its mask bit set.
- R11: While idle the counter holds, and byte strobes have no effect. A start code while busy is ignored: the mode and the counter keep their values.
- R12: A start code while idle with a count of 0 sets reason bit0 at once and does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_waddr_i | input | 3 | write word address |
| reg_wdata_i | input | REG_W | write data |
| reg_raddr_i | input | 3 | read word address |
| reg_rdata_o | output | REG_W | read data, combinational from `reg_raddr_i` |
| byte_vld_i | input | 1 | one byte moved this cycle |
| pkt_end_i | input | 1 | short or empty packet ended this cycle |
| busy_o | output | 1 | transfer in progress |
| dma_ep_o | output | EP_W | selected DMA endpoint buffer |
| irq_o | output | 1 | OR of the enabled reason bits |

## Verification
A register write, byte strobe or packet-end strobe changes the state on the next rising edge. The read data and `irq_o` are combinational from that state, so every result is due one cycle after its stimulus. Each driver task holds its stimulus for exactly one rising edge and hands its expected value to the scoreboard at the falling edge that follows. The monitor then sets the read address and compares the result within that same low phase, before the next edge can move anything.

// File: rtl/edma_pkg.sv
package edma_pkg;
  localparam int ADDR_W = 3;
  localparam int RSN_W  = 5;

  typedef enum logic [2:0] {
    A_EPIDX = 3'd0,
    A_DMAEP = 3'd1,
    A_COUNT = 3'd2,
    A_CMD   = 3'd3,
    A_RSN   = 3'd4,
    A_MASK  = 3'd5,
    A_STAT  = 3'd6
  } addr_e;

  typedef enum logic [3:0] {
    C_RESET    = 4'd1,
    C_GO_GEN   = 4'd2,
    C_GO_MEM   = 4'd3,
    C_HALT_GEN = 4'd4,
    C_HALT_MEM = 4'd5
  } cmd_e;

  localparam int RB_DONE  = 0;
  localparam int RB_EOT   = 1;
  localparam int RB_ABT_G = 2;
  localparam int RB_ABT_M = 3;
  localparam int RB_CFG   = 4;
endpackage

// File: rtl/edma_regs.sv
module edma_regs
  import edma_pkg::*;
#(
  parameter int EP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             ep_we_i,
  input  logic             dma_we_i,
  input  logic             mask_we_i,
  input  logic [EP_W-1:0]  ep_wdata_i,
  input  logic [RSN_W-1:0] mask_wdata_i,
  output logic [EP_W-1:0]  ep_idx_o,
  output logic [EP_W-1:0]  dma_ep_o,
  output logic [RSN_W-1:0] mask_o
);
  logic [EP_W-1:0]  ep_idx_q, dma_ep_q;
  logic [RSN_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_idx_q <= '0;
      dma_ep_q <= '0;
      mask_q   <= '0;
    end else begin
      if (ep_we_i) ep_idx_q <= ep_wdata_i;
      // the endpoint index belongs to firmware, not to the DMA state
      if (soft_rst_i) begin
        dma_ep_q <= '0;
        mask_q   <= '0;
      end else begin
        if (dma_we_i)  dma_ep_q <= ep_wdata_i;
        if (mask_we_i) mask_q   <= mask_wdata_i;
      end
    end
  end

  assign ep_idx_o = ep_idx_q;
  assign dma_ep_o = dma_ep_q;
  assign mask_o   = mask_q;

  AST_IDX_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i && !ep_we_i |=> $stable(ep_idx_q)); // R1
  AST_DMA_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (dma_ep_q == '0) && (mask_q == '0)); // R1
endmodule

// File: rtl/edma_engine.sv
module edma_engine
  import edma_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmd_we_i,
  input  logic [3:0]       cmd_i,
  input  logic             ep_clash_i,
  input  logic             byte_vld_i,
  input  logic             pkt_end_i,
  output logic             busy_o,
  output logic             mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [RSN_W-1:0] set_o
);
  logic             busy_q, busy_d;
  logic             mode_q, mode_d;   // 0 generic, 1 memory
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             go, stop_hit, stop_miss, last_byte;

  assign go        = cmd_we_i && !busy_q && (cmd_i == C_GO_GEN || cmd_i == C_GO_MEM);
  assign stop_hit  = cmd_we_i && busy_q &&
                     ((cmd_i == C_HALT_GEN && !mode_q) || (cmd_i == C_HALT_MEM && mode_q));
  assign stop_miss = cmd_we_i && busy_q &&
                     ((cmd_i == C_HALT_GEN && mode_q) || (cmd_i == C_HALT_MEM && !mode_q));
  assign last_byte = byte_vld_i && (cnt_q == CNT_W'(1));

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    set_o  = '0;
    if (busy_q) begin
      if (stop_hit) begin
        // an abort wins over a byte arriving in the same cycle
        busy_d = 1'b0;
        if (mode_q) set_o[RB_ABT_M] = 1'b1;
        else        set_o[RB_ABT_G] = 1'b1;
      end else begin
        if (byte_vld_i) cnt_d = cnt_q - 1'b1;
        if (last_byte) begin
          busy_d          = 1'b0;
          set_o[RB_DONE]  = 1'b1;
        end
        if (pkt_end_i) begin
          busy_d         = 1'b0;
          set_o[RB_EOT]  = 1'b1;
        end
      end
    end else begin
      if (cnt_we_i) cnt_d = cnt_wdata_i;
      if (go) begin
        if (ep_clash_i)           set_o[RB_CFG]  = 1'b1;
        else if (cnt_q == '0)     set_o[RB_DONE] = 1'b1;
        else begin
          busy_d = 1'b1;
          mode_d = (cmd_i == C_GO_MEM);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (soft_rst_i) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && byte_vld_i && !stop_hit && !soft_rst_i |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && last_byte && !soft_rst_i |=> !busy_q); // R4
  AST_EOT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && pkt_end_i && !soft_rst_i |=> !busy_q); // R5
  AST_CLASH_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && ep_clash_i && !soft_rst_i |=> !busy_q); // R9
  AST_MISS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_miss && !byte_vld_i && !pkt_end_i && !soft_rst_i |=> busy_q); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !cnt_we_i && !soft_rst_i |=> $stable(cnt_q)); // R11
  AST_BUSY_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !soft_rst_i |=> $stable(mode_q)); // R11
  AST_SOFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !busy_q && cnt_q == '0); // R1
endmodule

// File: rtl/edma_rsn.sv
module edma_rsn
  import edma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             clr_we_i,
  input  logic [RSN_W-1:0] clr_i,
  input  logic [RSN_W-1:0] set_i,
  input  logic [RSN_W-1:0] mask_i,
  output logic [RSN_W-1:0] rsn_o,
  output logic             irq_o
);
  logic [RSN_W-1:0] rsn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rsn_q <= '0;
    else if (soft_rst_i) rsn_q <= '0;
    else                 rsn_q <= (rsn_q & ~(clr_we_i ? clr_i : '0)) | set_i; // set wins
  end

  assign rsn_o = rsn_q;
  assign irq_o = |(rsn_q & mask_i);

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i && !soft_rst_i |=> (rsn_q & $past(rsn_q)) == $past(rsn_q)); // R10
  AST_SOFT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> rsn_q == '0 && !irq_o); // R1
endmodule

// File: rtl/edma_ctrl.sv
module edma_ctrl
  import edma_pkg::*;
#(
  parameter int EP_W  = 4,
  parameter int REG_W = 32,
  parameter int CNT_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              byte_vld_i,
  input  logic              pkt_end_i,
  output logic              busy_o,
  output logic [EP_W-1:0]   dma_ep_o,
  output logic              irq_o
);
  logic             cmd_we, soft_rst;
  logic [EP_W-1:0]  ep_idx, dma_ep;
  logic [RSN_W-1:0] mask, rsn, rsn_set;
  logic [CNT_W-1:0] cnt;
  logic             busy, mode;

  assign cmd_we   = reg_we_i && reg_waddr_i == A_CMD;
  assign soft_rst = cmd_we && reg_wdata_i[3:0] == C_RESET;

  edma_regs #(.EP_W(EP_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst),
    .ep_we_i      (reg_we_i && reg_waddr_i == A_EPIDX),
    .dma_we_i     (reg_we_i && reg_waddr_i == A_DMAEP),
    .mask_we_i    (reg_we_i && reg_waddr_i == A_MASK),
    .ep_wdata_i   (reg_wdata_i[EP_W-1:0]),
    .mask_wdata_i (reg_wdata_i[RSN_W-1:0]),
    .ep_idx_o     (ep_idx),
    .dma_ep_o     (dma_ep),
    .mask_o       (mask)
  );

  edma_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .cnt_we_i    (reg_we_i && reg_waddr_i == A_COUNT),
    .cnt_wdata_i (reg_wdata_i[CNT_W-1:0]),
    .cmd_we_i    (cmd_we),
    .cmd_i       (reg_wdata_i[3:0]),
    .ep_clash_i  (dma_ep == ep_idx),
    .byte_vld_i  (byte_vld_i),
    .pkt_end_i   (pkt_end_i),
    .busy_o      (busy),
    .mode_o      (mode),
    .cnt_o       (cnt),
    .set_o       (rsn_set)
  );

  edma_rsn u_rsn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .clr_we_i   (reg_we_i && reg_waddr_i == A_RSN),
    .clr_i      (reg_wdata_i[RSN_W-1:0]),
    .set_i      (rsn_set),
    .mask_i     (mask),
    .rsn_o      (rsn),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (reg_raddr_i)
      A_EPIDX: reg_rdata_o = REG_W'(ep_idx);
      A_DMAEP: reg_rdata_o = REG_W'(dma_ep);
      A_COUNT: reg_rdata_o = REG_W'(cnt);
      A_RSN:   reg_rdata_o = REG_W'(rsn);
      A_MASK:  reg_rdata_o = REG_W'(mask);
      A_STAT:  reg_rdata_o = REG_W'({mode, busy});
      default: reg_rdata_o = '0;
    endcase
  end

  assign busy_o   = busy;
  assign dma_ep_o = dma_ep;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we && !busy && reg_wdata_i[3:0] == C_GO_MEM && dma_ep != ep_idx && cnt != '0
    |=> busy && mode); // R2
endmodule

// File: tb/sim_edma_ctrl.sv
module sim_edma_ctrl;
  localparam int EP_W = 4;
  localparam int REG_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0;
  logic [2:0]       waddr = '0;
  logic [REG_W-1:0] wdata = '0;
  logic [2:0]       raddr = '0;
  logic [REG_W-1:0] rdata;
  logic             bvld = 1'b0;
  logic             pend = 1'b0;
  logic             busy;
  logic [EP_W-1:0]  dma_ep;
  logic             irq;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int served = 0;

  typedef struct {
    logic [2:0]  a;
    logic [31:0] e;
    int          irq_e;   // -1: irq not checked
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  edma_ctrl #(.EP_W(EP_W), .REG_W(REG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .byte_vld_i(bvld), .pkt_end_i(pend), .busy_o(busy), .dma_ep_o(dma_ep),
    .irq_o(irq)
  );

  // monitor: pops expectations and compares within the low clock phase
  initial begin
    forever begin
      exp_t it;
      wait (q.size() != 0);
      it = q.pop_front();
      raddr = it.a;
      #1;
      checks++;
      if (rdata !== it.e) begin
        errors++;
        $display("FAIL %s addr %0d actual %0h expected %0h", it.tag, it.a, rdata, it.e);
      end
      if (it.irq_e >= 0) begin
        checks++;
        if (irq !== it.irq_e[0]) begin
          errors++;
          $display("FAIL %s irq actual %0b expected %0b", it.tag, irq, it.irq_e[0]);
        end
      end
      served++;
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input int ie,
                            input string tag);
    exp_t it;
    it.a = a; it.e = e; it.irq_e = ie; it.tag = tag;
    q.push_back(it);
    pushed++;
    wait (served == pushed);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bytes(input int n, input bit end_last);
    for (int i = 0; i < n; i++) begin
      bvld = 1'b1;
      pend = end_last && (i == n - 1);
      @(negedge clk);
    end
    bvld = 1'b0;
    pend = 1'b0;
  endtask

  task automatic eot_only();
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg(3'd6, 32'h0, 0, "R1 reset status");
    expect_reg(3'd4, 32'h0, 0, "R1 reset reason");

    // R9: endpoint clash refuses start
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd4);
    wr(3'd3, 32'd2);
    expect_reg(3'd6, 32'h0, -1, "R9 not busy");
    expect_reg(3'd4, 32'h10, 0, "R9 cfg bit, masked irq");
    wr(3'd4, 32'h1F);
    expect_reg(3'd4, 32'h0, -1, "R10 w1c clear");

    // R2/R3/R8/R11/R4: generic transfer runs out
    wr(3'd1, 32'd3);
    wr(3'd5, 32'h1F);
    wr(3'd3, 32'd2);
    expect_reg(3'd6, 32'h1, 0, "R2 generic busy");
    bytes(3, 1'b0);
    expect_reg(3'd2, 32'd1, -1, "R3 count after 3 bytes");
    wr(3'd3, 32'd5);
    expect_reg(3'd6, 32'h1, -1, "R8 memory stop ignored");
    expect_reg(3'd4, 32'h0, 0, "R8 no reason bit");
    wr(3'd3, 32'd3);
    expect_reg(3'd6, 32'h1, -1, "R11 start while busy keeps mode");
    expect_reg(3'd2, 32'd1, -1, "R11 start while busy keeps count");
    bytes(1, 1'b0);
    expect_reg(3'd6, 32'h0, -1, "R4 busy cleared");
    expect_reg(3'd4, 32'h1, 1, "R4 done bit, R10 irq");
    wr(3'd4, 32'h1);
    expect_reg(3'd4, 32'h0, 0, "R10 cleared, irq low");
    bytes(2, 1'b0);
    expect_reg(3'd2, 32'd0, -1, "R11 idle bytes ignored");

    // R5: short packet mid-transfer in memory mode
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd3);
    expect_reg(3'd6, 32'h3, -1, "R2 memory busy");
    bytes(2, 1'b0);
    eot_only();
    expect_reg(3'd4, 32'h2, 1, "R5 eot bit");
    expect_reg(3'd6, 32'h2, -1, "R5 busy cleared");
    expect_reg(3'd2, 32'd3, -1, "R5 remaining count");
    wr(3'd4, 32'h1F);

    // R6: last byte is also a short packet end
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd2);
    bytes(2, 1'b1);
    expect_reg(3'd4, 32'h3, 1, "R6 done and eot together");
    expect_reg(3'd6, 32'h0, -1, "R6 busy cleared");
    wr(3'd4, 32'h1F);

    // R7/R8/R10: aborts per mode, masked irq
    wr(3'd5, 32'h2);
    wr(3'd2, 32'd6);
    wr(3'd3, 32'd3);
    wr(3'd3, 32'd4);
    expect_reg(3'd6, 32'h3, -1, "R8 generic stop ignored in memory mode");
    expect_reg(3'd4, 32'h0, -1, "R8 no reason bit");
    wr(3'd3, 32'd5);
    expect_reg(3'd4, 32'h8, 0, "R7 memory abort bit, R10 masked");
    expect_reg(3'd6, 32'h2, -1, "R7 busy cleared");
    wr(3'd4, 32'h1F);
    wr(3'd3, 32'd2);
    wr(3'd3, 32'd4);
    expect_reg(3'd4, 32'h4, -1, "R7 generic abort bit");
    wr(3'd4, 32'h1F);
    wr(3'd3, 32'd4);
    expect_reg(3'd4, 32'h0, -1, "R8 stop while idle ignored");

    // R12: start with zero count
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd2);
    expect_reg(3'd4, 32'h1, -1, "R12 done at once");
    expect_reg(3'd6, 32'h0, -1, "R12 never busy");

    // R1: reset command mid-transfer
    wr(3'd5, 32'h1F);
    wr(3'd2, 32'd9);
    wr(3'd3, 32'd3);
    expect_reg(3'd6, 32'h3, 1, "R1 pre-reset busy, irq");
    wr(3'd3, 32'd1);
    expect_reg(3'd6, 32'h0, 0, "R1 status cleared");
    expect_reg(3'd2, 32'd0, -1, "R1 count cleared");
    expect_reg(3'd4, 32'h0, -1, "R1 reason cleared");
    expect_reg(3'd5, 32'h0, -1, "R1 mask cleared");
    expect_reg(3'd1, 32'h0, -1, "R1 dma endpoint cleared");
    expect_reg(3'd0, 32'h1, -1, "R1 endpoint index kept");

    finish_run();
  end
endmodule